// File: doc/BRIEF.md
# SDRAM Command Bus Monitor

This block sits on one SDRAM command bus and watches it every clock. It turns the raw control pins (clock enable, chip select, row strobe, column strobe, write enable, two bank-address bits, address bit A10 and the data mask) into a named command. It keeps a small state machine for each of the four banks: idle, open, running a burst that will close itself, or recovering after such a burst. When a command breaks an issue rule, it reports a violation together with an error code. The report is combinational and lasts only for the cycle of the offending command.

A command that is reported as a violation does not change any bank state. A monitor or protocol checker can therefore keep running after the first error. The block also produces the two mask signals that the data mask implies. The write mask acts in the same cycle. The read output-disable appears two cycles after the mask was sampled.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With chip select low, {RAS,CAS,WE} decodes as 000 mode set (code 1), 001 refresh, 011 activate (4), 101 read (5), 100 write (6), 110 burst stop (7), 010 precharge (8 single bank, 9 all banks), and 111 no-operation (0). Chip select high also decodes to no-operation (0).
- R2: A refresh in a cycle where clock enable is low but was high in the previous cycle decodes as self-refresh entry (code 3). Any other refresh decodes as auto refresh (code 2).
- R3: The addressed bank index on `bank_o` is {BA0,BA1}: 00 gives bank 0, BA1 alone gives bank 1, BA0 alone gives bank 2, and 11 gives bank 3.
- R4: Mode set, auto refresh and self-refresh entry while any bank is not idle flag error code 1.
- R5: In the 2 cycles after an accepted mode set, any command other than no-operation flags error code 2. This check takes priority over all other checks.
- R6: A read or write to a bank that is not open flags error code 3. An activate to a bank that is open or running a self-closing burst flags error code 5.
- R7: A read or write with A10 high starts a self-closing burst of BURST_LEN cycles, counting the command cycle. While that burst runs, a read or write to any bank flags error code 4.
- R8: After a self-closing burst ends, an activate to that bank flags error code 6 for TRP_CYC cycles. After that it is accepted.
- R9: A precharge with A10 high closes all open banks and ignores the bank bits. With A10 low it closes only the addressed bank.
- R10: A burst stop never flags a violation outside the mode-set gap. It ends any running self-closing burst at once, and that bank then enters its recovery time.
- R11: `wr_mask_o` equals the data mask in the same cycle. `rd_hiz_o` equals the data mask sampled 2 cycles earlier.
- R12: A command that flags a violation leaves all bank state unchanged. `viol_o` is high exactly in the cycles where `err_o` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank-address bits, ba[0] is BA0 |
| a10 | input | 1 | Address bit A10 (auto-close / all-banks) |
| dqm | input | 1 | Data mask |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Addressed bank index |
| viol_o | output | 1 | Issue-rule violation this cycle |
| err_o | output | 3 | Error code, 0 when legal |
| wr_mask_o | output | 1 | Write data mask, latency 0 |
| rd_hiz_o | output | 1 | Read output disable, latency 2 |

## Verification
The assertions assume that every input is a known level on each rising edge once the internal reset has been released. They also assume the data mask has been stable for two cycles before the read-latency check is enabled, which is why that check waits for a warm-up count. The stimulus changes every pin only on the falling edge and holds the mask low throughout reset. Each command is held for a whole cycle, so bank state never sees a partial command.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_MRS  = 4'd1,
    CMD_AREF = 4'd2,
    CMD_SREF = 4'd3,
    CMD_ACT  = 4'd4,
    CMD_RD   = 4'd5,
    CMD_WR   = 4'd6,
    CMD_BST  = 4'd7,
    CMD_PRE  = 4'd8,
    CMD_PREA = 4'd9
  } cmd_e;

  typedef enum logic [1:0] {
    BS_IDLE    = 2'd0,
    BS_ACTIVE  = 2'd1,
    BS_APBURST = 2'd2,
    BS_RECOVER = 2'd3
  } bank_st_e;

  typedef enum logic [2:0] {
    ERR_NONE         = 3'd0,
    ERR_NOT_ALL_IDLE = 3'd1,
    ERR_MRS_GAP      = 3'd2,
    ERR_BANK_CLOSED  = 3'd3,
    ERR_AP_BURST     = 3'd4,
    ERR_ROW_OPEN     = 3'd5,
    ERR_TRP_WAIT     = 3'd6
  } err_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cke,
  input  logic cke_prev,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = (cke_prev && !cke) ? CMD_SREF : CMD_AREF;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_BST;
        3'b010:  cmd = a10 ? CMD_PREA : CMD_PRE;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_slice.sv
module sdram_bank_slice
  import sdram_mon_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int TRP_CYC   = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel,
  input  cmd_e     cmd,
  input  logic     ap,
  input  logic     accept,
  output bank_st_e st
);

  localparam int CNT_MAX = (BURST_LEN > TRP_CYC) ? BURST_LEN : TRP_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int BL_LOAD = (BURST_LEN > 1) ? BURST_LEN - 2 : 0;
  localparam logic [CW-1:0] BURST_INIT = CW'(BL_LOAD);
  localparam logic [CW-1:0] TRP_INIT   = CW'(TRP_CYC - 1);

  bank_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          is_rw;

  assign is_rw = (cmd == CMD_RD) || (cmd == CMD_WR);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      BS_IDLE: begin
        if (accept && sel && cmd == CMD_ACT) st_d = BS_ACTIVE;
      end
      BS_ACTIVE: begin
        if (accept && ((sel && cmd == CMD_PRE) || cmd == CMD_PREA)) begin
          st_d = BS_IDLE;
        end else if (accept && sel && ap && is_rw) begin
          if (BURST_LEN > 1) begin
            st_d  = BS_APBURST;
            cnt_d = BURST_INIT;
          end else begin
            st_d  = BS_RECOVER;
            cnt_d = TRP_INIT;
          end
        end
      end
      BS_APBURST: begin
        if ((accept && cmd == CMD_BST) || cnt_q == '0) begin
          st_d  = BS_RECOVER;
          cnt_d = TRP_INIT;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      BS_RECOVER: begin
        if (cnt_q == '0) st_d = BS_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st = st_q;

endmodule

// File: rtl/sdram_mask_pipe.sv
module sdram_mask_pipe #(
  parameter int RD_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dqm,
  output logic wr_mask,
  output logic rd_hiz
);

  assign wr_mask = dqm;

  generate
    if (RD_LAT == 0) begin : g_no_lat
      assign rd_hiz = dqm;
    end else begin : g_lat
      logic [RD_LAT-1:0] sh_q, sh_d;

      always_comb begin
        sh_d    = sh_q << 1;
        sh_d[0] = dqm;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
      end

      assign rd_hiz = sh_q[RD_LAT-1];
    end
  endgenerate

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BA_W       = 2,
  parameter int BURST_LEN  = 4,
  parameter int TRP_CYC    = 2,
  parameter int MRS_GAP    = 2,
  parameter int RD_DQM_LAT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  input  logic            dqm,
  output logic [3:0]      cmd_o,
  output logic [BA_W-1:0] bank_o,
  output logic            viol_o,
  output logic [2:0]      err_o,
  output logic            wr_mask_o,
  output logic            rd_hiz_o
);

  localparam int NUM_BANKS = 1 << BA_W;
  localparam int GW        = $clog2(MRS_GAP + 1);
  localparam logic [GW-1:0] GAP_INIT = GW'(MRS_GAP);

  logic [1:0]      rs_q;
  logic            rst_int_n;
  logic            cke_q;
  logic [GW-1:0]   gap_q, gap_d;
  logic [BA_W-1:0] bank_idx;
  cmd_e            cmd;
  err_e            err;
  logic            accept;
  logic            any_burst, all_idle;
  bank_st_e        sel_st;
  bank_st_e [NUM_BANKS-1:0] bank_st;

  // reset: asserted at once, released after two clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  sdram_cmd_decode u_dec (
    .cke      (cke),
    .cke_prev (cke_q),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .a10      (a10),
    .cmd      (cmd)
  );

  // bank bits are weighted in reverse order
  always_comb begin
    for (int i = 0; i < BA_W; i++) bank_idx[i] = ba[BA_W-1-i];
  end

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      sdram_bank_slice #(
        .BURST_LEN (BURST_LEN),
        .TRP_CYC   (TRP_CYC)
      ) u_slice (
        .clk    (clk),
        .rst_n  (rst_int_n),
        .sel    (bank_idx == BA_W'(b)),
        .cmd    (cmd),
        .ap     (a10),
        .accept (accept),
        .st     (bank_st[b])
      );
    end
  endgenerate

  always_comb begin
    any_burst = 1'b0;
    all_idle  = 1'b1;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (bank_st[i] == BS_APBURST) any_burst = 1'b1;
      if (bank_st[i] != BS_IDLE)    all_idle  = 1'b0;
    end
  end

  assign sel_st = bank_st[bank_idx];

  always_comb begin
    err = ERR_NONE;
    if (gap_q != '0 && cmd != CMD_NOP) begin
      err = ERR_MRS_GAP;
    end else begin
      case (cmd)
        CMD_MRS, CMD_AREF, CMD_SREF: begin
          if (!all_idle) err = ERR_NOT_ALL_IDLE;
        end
        CMD_RD, CMD_WR: begin
          if (any_burst)                err = ERR_AP_BURST;
          else if (sel_st != BS_ACTIVE) err = ERR_BANK_CLOSED;
        end
        CMD_ACT: begin
          if (sel_st == BS_ACTIVE || sel_st == BS_APBURST) err = ERR_ROW_OPEN;
          else if (sel_st == BS_RECOVER)                   err = ERR_TRP_WAIT;
        end
        default: err = ERR_NONE;
      endcase
    end
  end

  assign accept = (err == ERR_NONE);

  always_comb begin
    if (cmd == CMD_MRS && accept) gap_d = GAP_INIT;
    else if (gap_q != '0)         gap_d = gap_q - 1'b1;
    else                          gap_d = gap_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      gap_q <= '0;
      cke_q <= 1'b1;
    end else begin
      gap_q <= gap_d;
      cke_q <= cke;
    end
  end

  sdram_mask_pipe #(
    .RD_LAT (RD_DQM_LAT)
  ) u_mask (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .dqm     (dqm),
    .wr_mask (wr_mask_o),
    .rd_hiz  (rd_hiz_o)
  );

  assign cmd_o  = cmd;
  assign bank_o = bank_idx;
  assign err_o  = err;
  assign viol_o = !accept;

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk
  import sdram_mon_pkg::*;
#(
  parameter int BA_W       = 2,
  parameter int NUM_BANKS  = 4,
  parameter int RD_DQM_LAT = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     dqm,
  input logic [3:0]               cmd_o,
  input logic [BA_W-1:0]          bank_o,
  input logic                     viol_o,
  input logic [2:0]               err_o,
  input logic                     rd_hiz_o,
  input bank_st_e [NUM_BANKS-1:0] bank_st
);

  logic [1:0]      warm_q;
  logic [BA_W-1:0] last_bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q      <= '0;
      last_bank_q <= '0;
    end else begin
      if (warm_q != 2'd3) warm_q <= warm_q + 1'b1;
      last_bank_q <= bank_o;
    end
  end

  // R5
  mrs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_MRS && !viol_o) |=> (cmd_o == CMD_NOP || err_o == ERR_MRS_GAP));

  // R1
  nop_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_NOP) |-> !viol_o);

  // R6
  rw_open_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o == CMD_RD || cmd_o == CMD_WR) && !viol_o) |-> bank_st[bank_o] == BS_ACTIVE);

  // R12
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_ACT && !viol_o) |=> bank_st[last_bank_q] == BS_ACTIVE);

  // R7
  burst_err_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o == ERR_AP_BURST) |-> (cmd_o == CMD_RD || cmd_o == CMD_WR));

  // R11
  generate
    if (RD_DQM_LAT == 2) begin : g_lat2
      rd_hiz_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> rd_hiz_o == $past(dqm, 2));
    end
  endgenerate

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(
  .BA_W       (BA_W),
  .NUM_BANKS  (NUM_BANKS),
  .RD_DQM_LAT (RD_DQM_LAT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .dqm      (dqm),
  .cmd_o    (cmd_o),
  .bank_o   (bank_o),
  .viol_o   (viol_o),
  .err_o    (err_o),
  .rd_hiz_o (rd_hiz_o),
  .bank_st  (bank_st)
);

// File: tb/test_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module test_sdram_cmd_monitor;

  // drive kinds
  localparam logic [3:0] D_NOP = 4'd0, D_MRS = 4'd1, D_REF = 4'd2, D_ACT = 4'd4,
                         D_RD = 4'd5, D_WR = 4'd6, D_BST = 4'd7, D_PRE = 4'd8,
                         D_DESEL = 4'd10;
  // expected command codes
  localparam logic [3:0] C_NOP = 4'd0, C_MRS = 4'd1, C_AREF = 4'd2, C_SREF = 4'd3,
                         C_ACT = 4'd4, C_RD = 4'd5, C_WR = 4'd6, C_BST = 4'd7,
                         C_PRE = 4'd8, C_PREA = 4'd9;

  localparam int NV = 21;
  // {drive, ba, a10, expected cmd, expected err}; burst length 4, recovery 2
  localparam logic [13:0] VECS [0:NV-1] = '{
    {D_MRS,   2'b00, 1'b0, C_MRS,  3'd0},  // 0  R4 legal, all idle
    {D_ACT,   2'b00, 1'b0, C_ACT,  3'd2},  // 1  R5 gap
    {D_NOP,   2'b00, 1'b0, C_NOP,  3'd0},  // 2  R5 gap, nop ok
    {D_ACT,   2'b00, 1'b0, C_ACT,  3'd0},  // 3  R12 bank 0 still idle
    {D_MRS,   2'b00, 1'b0, C_MRS,  3'd1},  // 4  R4
    {D_REF,   2'b00, 1'b0, C_AREF, 3'd1},  // 5  R4
    {D_ACT,   2'b00, 1'b0, C_ACT,  3'd5},  // 6  R6 row open
    {D_RD,    2'b01, 1'b0, C_RD,   3'd3},  // 7  R6 bank 2 closed
    {D_WR,    2'b00, 1'b0, C_WR,   3'd0},  // 8  R6 legal write
    {D_RD,    2'b00, 1'b1, C_RD,   3'd0},  // 9  R7 burst starts
    {D_WR,    2'b00, 1'b0, C_WR,   3'd4},  // 10 R7 same bank
    {D_ACT,   2'b10, 1'b0, C_ACT,  3'd0},  // 11 R7 activate other bank ok
    {D_RD,    2'b10, 1'b0, C_RD,   3'd4},  // 12 R7 other bank, last beat
    {D_RD,    2'b10, 1'b0, C_RD,   3'd0},  // 13 R7 burst over
    {D_ACT,   2'b00, 1'b0, C_ACT,  3'd6},  // 14 R8 still recovering
    {D_ACT,   2'b00, 1'b0, C_ACT,  3'd0},  // 15 R8 recovery done
    {D_PRE,   2'b01, 1'b1, C_PREA, 3'd0},  // 16 R9 all banks
    {D_RD,    2'b10, 1'b0, C_RD,   3'd3},  // 17 R9 bank 1 closed
    {D_DESEL, 2'b00, 1'b0, C_NOP,  3'd0},  // 18 R1 deselect
    {D_REF,   2'b00, 1'b0, C_AREF, 3'd0},  // 19 R4 legal refresh
    {D_NOP,   2'b00, 1'b0, C_NOP,  3'd0}   // 20 R1 explicit nop
  };
  localparam string TAGS [0:NV-1] = '{
    "R4", "R5", "R5", "R12", "R4", "R4", "R6", "R6", "R6", "R7", "R7",
    "R7", "R7", "R7", "R8", "R8", "R9", "R9", "R1", "R4", "R1"
  };

  logic       clk, rst_n, cke, cs_n, ras_n, cas_n, we_n, a10, dqm;
  logic [1:0] ba;
  logic [3:0] cmd_o;
  logic [1:0] bank_o;
  logic       viol_o, wr_mask_o, rd_hiz_o;
  logic [2:0] err_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  sdram_cmd_monitor #(
    .BA_W (2), .BURST_LEN (4), .TRP_CYC (2), .MRS_GAP (2), .RD_DQM_LAT (2)
  ) i_sdram_cmd_monitor (
    .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
    .cas_n (cas_n), .we_n (we_n), .ba (ba), .a10 (a10), .dqm (dqm),
    .cmd_o (cmd_o), .bank_o (bank_o), .viol_o (viol_o), .err_o (err_o),
    .wr_mask_o (wr_mask_o), .rd_hiz_o (rd_hiz_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic expect_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] drv, input logic [1:0] b, input logic a,
                      input logic m, input logic ck);
    @(negedge clk);
    cke = ck; ba = b; a10 = a; dqm = m; cs_n = 1'b0;
    case (drv)
      D_MRS:   {ras_n, cas_n, we_n} = 3'b000;
      D_REF:   {ras_n, cas_n, we_n} = 3'b001;
      D_ACT:   {ras_n, cas_n, we_n} = 3'b011;
      D_RD:    {ras_n, cas_n, we_n} = 3'b101;
      D_WR:    {ras_n, cas_n, we_n} = 3'b100;
      D_BST:   {ras_n, cas_n, we_n} = 3'b110;
      D_PRE:   {ras_n, cas_n, we_n} = 3'b010;
      D_DESEL: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; end
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
    #1;
  endtask

  task automatic cmd_err(input logic [3:0] drv, input logic [1:0] b, input logic a,
                         input int ecmd, input int eerr, input string tag);
    step(drv, b, a, 1'b0, 1'b1);
    expect_eq({tag, " cmd"}, int'(cmd_o), ecmd);
    expect_eq({tag, " err"}, int'(err_o), eerr);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(4 * 50000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    ba = 2'b00; a10 = 1'b0; dqm = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    step(D_NOP, 2'b00, 1'b0, 1'b0, 1'b1);
    expect_eq("R12 reset viol", int'(viol_o), 0);
    expect_eq("R1 reset cmd", int'(cmd_o), 0);
    expect_eq("R11 reset rd_hiz", int'(rd_hiz_o), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      step(VECS[i][13:10], VECS[i][9:8], VECS[i][7], 1'b0, 1'b1);
      expect_eq($sformatf("R1 row %0d cmd", i), int'(cmd_o), int'(VECS[i][6:3]));
      expect_eq($sformatf("%s row %0d err", TAGS[i], i), int'(err_o), int'(VECS[i][2:0]));
      expect_eq($sformatf("R12 row %0d viol", i), int'(viol_o), int'(VECS[i][2:0] != 3'd0));
    end

    // R3 bank bit weighting
    step(D_ACT, 2'b10, 1'b0, 1'b0, 1'b1);
    expect_eq("R3 BA1 only", int'(bank_o), 1);
    step(D_ACT, 2'b01, 1'b0, 1'b0, 1'b1);
    expect_eq("R3 BA0 only", int'(bank_o), 2);
    step(D_ACT, 2'b11, 1'b0, 1'b0, 1'b1);
    expect_eq("R3 both", int'(bank_o), 3);
    cmd_err(D_PRE, 2'b00, 1'b1, C_PREA, 0, "R9");

    // R9 single-bank precharge
    cmd_err(D_ACT, 2'b00, 1'b0, C_ACT, 0, "R9");
    cmd_err(D_ACT, 2'b11, 1'b0, C_ACT, 0, "R9");
    cmd_err(D_PRE, 2'b11, 1'b0, C_PRE, 0, "R9");
    cmd_err(D_RD,  2'b00, 1'b0, C_RD,  0, "R9");
    cmd_err(D_RD,  2'b11, 1'b0, C_RD,  3, "R9");

    // R10 burst stop
    cmd_err(D_BST, 2'b00, 1'b0, C_BST, 0, "R10");
    cmd_err(D_ACT, 2'b11, 1'b0, C_ACT, 0, "R10");
    cmd_err(D_WR,  2'b11, 1'b1, C_WR,  0, "R10");
    cmd_err(D_BST, 2'b00, 1'b0, C_BST, 0, "R10");
    cmd_err(D_RD,  2'b00, 1'b0, C_RD,  0, "R10");
    cmd_err(D_ACT, 2'b11, 1'b0, C_ACT, 6, "R10");
    cmd_err(D_ACT, 2'b11, 1'b0, C_ACT, 0, "R10");
    cmd_err(D_PRE, 2'b00, 1'b1, C_PREA, 0, "R10");

    // R2 self refresh on falling clock enable
    step(D_REF, 2'b00, 1'b0, 1'b0, 1'b0);
    expect_eq("R2 self refresh", int'(cmd_o), C_SREF);
    expect_eq("R2 self refresh err", int'(err_o), 0);
    step(D_NOP, 2'b00, 1'b0, 1'b0, 1'b1);
    step(D_REF, 2'b00, 1'b0, 1'b0, 1'b1);
    expect_eq("R2 auto refresh", int'(cmd_o), C_AREF);

    // R11 mask latencies
    step(D_NOP, 2'b00, 1'b0, 1'b1, 1'b1);
    expect_eq("R11 wr mask now", int'(wr_mask_o), 1);
    expect_eq("R11 rd hiz +0", int'(rd_hiz_o), 0);
    step(D_NOP, 2'b00, 1'b0, 1'b0, 1'b1);
    expect_eq("R11 wr mask off", int'(wr_mask_o), 0);
    expect_eq("R11 rd hiz +1", int'(rd_hiz_o), 0);
    step(D_NOP, 2'b00, 1'b0, 1'b0, 1'b1);
    expect_eq("R11 rd hiz +2", int'(rd_hiz_o), 1);
    step(D_NOP, 2'b00, 1'b0, 1'b0, 1'b1);
    expect_eq("R11 rd hiz +3", int'(rd_hiz_o), 0);

    finish_run();
  end

endmodule